// File: doc/BRIEF.md
# Three-Axis Level Detector

This block takes one signed sample per axis (X, Y and Z) together with a valid strobe. It decides for each axis whether the sample crosses a programmable threshold, and it folds the three per-axis results into a single level event. Control inputs choose the following:

- which axes take part;
- whether the threshold is applied to the sample magnitude or treated as a signed level;
- whether a hit means "at or beyond the threshold" or "inside the threshold".

The same polarity control also picks the combining rule. Positive polarity fires when any enabled axis hits. Negative polarity fires only when every enabled axis hits.

The results are registered. They change only on the cycle after a valid strobe and hold their value in between. A filter bandwidth select travels through the same register, so downstream filtering logic sees it aligned with the detection result. Filtering, pulse timing and interrupt latching belong to neighbouring blocks.

Top module: `lvl_detect_top`

## Requirements
- R1: On a clock edge where `sample_vld` is 1, `axis_hit`, `level_evt` and `bw_sel_q` take the values computed from that cycle's inputs. They become visible after that edge. On an edge where `sample_vld` is 0, all three outputs keep their previous values, whatever the other inputs do.
- R2: `axis_off[0]`, `axis_off[1]` and `axis_off[2]` disable X, Y and Z respectively. A disabled axis drives its `axis_hit` bit to 0. `axis_hit[0]` is X, `axis_hit[1]` is Y and `axis_hit[2]` is Z.
- R3: With `thr_signed`=0 and `neg_pol`=0, an enabled axis hits when the absolute value of its sample is greater than or equal to `thresh`. Here `thresh` is read as unsigned (0..255), and a sample of -128 has magnitude 128.
- R4: With `thr_signed`=0 and `neg_pol`=1, an enabled axis hits when the absolute value of its sample is strictly below `thresh`.
- R5: With `thr_signed`=1, `thresh` is read as a two's complement value (-128..127). An enabled axis hits when sample >= `thresh` if `neg_pol`=0, and when sample < `thresh` if `neg_pol`=1.
- R6: With `neg_pol`=0, `level_evt` is 1 when at least one enabled axis hits.
- R7: With `neg_pol`=1, `level_evt` is 1 when every enabled axis hits and at least one axis is enabled.
- R8: With `neg_pol`=1 and all three axes disabled, `level_evt` is 0.
- R9: `bw_sel_q` carries the `bw_sel` value (0 = narrow band, 1 = wide band) that was sampled with the last valid strobe.
- R10: While `rst_n` is 0, `axis_hit`, `level_evt` and `bw_sel_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | Samples and controls are valid this cycle |
| axis_x | input | SAMPLE_W | Signed X sample |
| axis_y | input | SAMPLE_W | Signed Y sample |
| axis_z | input | SAMPLE_W | Signed Z sample |
| thresh | input | SAMPLE_W | Threshold (unsigned or signed per `thr_signed`) |
| axis_off | input | 3 | Per-axis disable, bit 0 = X |
| thr_signed | input | 1 | 0 = magnitude compare, 1 = signed compare |
| neg_pol | input | 1 | 0 = positive polarity with OR, 1 = negative polarity with AND |
| bw_sel | input | 1 | Filter bandwidth select to pass through |
| axis_hit | output | 3 | Registered per-axis hit flags |
| level_evt | output | 1 | Registered combined level event |
| bw_sel_q | output | 1 | Registered bandwidth select |

## Verification
The bench builds the block with the default `SAMPLE_W` of 8. At that width the extreme codes can all be driven directly: a sample of -128 against a threshold of 128, a threshold of 0, and thresholds with the top bit set that mean a large magnitude in one mode and a negative level in the other. One input set is applied in both threshold modes, so that the two modes give different hit patterns on the same samples.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
    localparam int LVL_AXES = 3;

    typedef struct packed {
        logic [LVL_AXES-1:0] hit;
        logic                evt;
        logic                bw;
    } lvl_state_t;
endpackage

// File: rtl/lvl_axis_cmp.sv
module lvl_axis_cmp #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] thr,
    input  logic          thr_signed,
    input  logic          neg_pol,
    input  logic          axis_off,
    output logic          hit
);
    localparam int EW = SW + 1;

    logic [EW-1:0] mag_d;
    logic [EW-1:0] thr_u_d;
    logic          reach_d;

    always_comb begin
        mag_d = {1'b0, sample};
        if (sample[SW-1]) begin
            mag_d = ~{1'b1, sample} + {{(EW-1){1'b0}}, 1'b1};
        end
        thr_u_d = {1'b0, thr};
        if (thr_signed) begin
            reach_d = ($signed(sample) >= $signed(thr));
        end else begin
            reach_d = (mag_d >= thr_u_d);
        end
        hit = !axis_off && (neg_pol ? !reach_d : reach_d);
    end
endmodule

// File: rtl/lvl_combine.sv
module lvl_combine #(
    parameter int N = 3
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] off,
    input  logic         neg_pol,
    output logic         evt
);
    always_comb begin
        if (neg_pol) begin
            evt = (&(hit | off)) && !(&off);
        end else begin
            evt = |hit;
        end
    end
endmodule

// File: rtl/lvl_detect_top.sv
module lvl_detect_top
    import lvl_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_vld,
    input  logic [SAMPLE_W-1:0] axis_x,
    input  logic [SAMPLE_W-1:0] axis_y,
    input  logic [SAMPLE_W-1:0] axis_z,
    input  logic [SAMPLE_W-1:0] thresh,
    input  logic [2:0]          axis_off,
    input  logic                thr_signed,
    input  logic                neg_pol,
    input  logic                bw_sel,
    output logic [2:0]          axis_hit,
    output logic                level_evt,
    output logic                bw_sel_q
);
    logic [SAMPLE_W-1:0] smp [LVL_AXES];
    logic [LVL_AXES-1:0] hit_c;
    logic                evt_c;
    lvl_state_t          st_d;
    lvl_state_t          st_q;

    assign smp[0] = axis_x;
    assign smp[1] = axis_y;
    assign smp[2] = axis_z;

    for (genvar a = 0; a < LVL_AXES; a++) begin : g_axis
        lvl_axis_cmp #(.SW(SAMPLE_W)) u_cmp (
            .sample     (smp[a]),
            .thr        (thresh),
            .thr_signed (thr_signed),
            .neg_pol    (neg_pol),
            .axis_off   (axis_off[a]),
            .hit        (hit_c[a])
        );
    end

    lvl_combine #(.N(LVL_AXES)) u_comb (
        .hit     (hit_c),
        .off     (axis_off),
        .neg_pol (neg_pol),
        .evt     (evt_c)
    );

    always_comb begin
        st_d = st_q;
        if (sample_vld) begin
            st_d.hit = hit_c;
            st_d.evt = evt_c;
            st_d.bw  = bw_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign axis_hit  = st_q.hit;
    assign level_evt = st_q.evt;
    assign bw_sel_q  = st_q.bw;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(axis_hit) && $stable(level_evt) && $stable(bw_sel_q))) // R1
        else $error("hold violated");
    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> ((axis_hit & $past(axis_off)) == 3'b000)) // R2
        else $error("disabled axis hit");
    AST_OR_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !neg_pol) |=> (level_evt == (|axis_hit))) // R6
        else $error("OR combine mismatch");
    AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && neg_pol && (&axis_off)) |=> !level_evt) // R8
        else $error("event with all axes off");
    AST_BW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> (bw_sel_q == $past(bw_sel))) // R9
        else $error("bandwidth select mismatch");
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (axis_hit == 3'b000 && !level_evt && !bw_sel_q)) // R10
        else $error("reset state wrong");
endmodule

// File: tb/sim_lvl_detect_top.sv
module sim_lvl_detect_top;
    typedef struct packed {
        logic       bw;
        logic [2:0] off;
        logic       ts;
        logic       np;
        logic [7:0] x;
        logic [7:0] y;
        logic [7:0] z;
        logic [7:0] thr;
        logic [2:0] eh;
        logic       ee;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R3 R6: |y|=20 reaches 15
        '{1'b0, 3'b000, 1'b0, 1'b0, 8'h0A, 8'hEC, 8'h05, 8'h0F, 3'b010, 1'b1},
        // R4 R7: x,z below 15, y not
        '{1'b1, 3'b000, 1'b0, 1'b1, 8'h0A, 8'hEC, 8'h05, 8'h0F, 3'b101, 1'b0},
        // R4 R7: all below 4
        '{1'b0, 3'b000, 1'b0, 1'b1, 8'h01, 8'hFE, 8'h03, 8'h04, 3'b111, 1'b1},
        // R3: -128 has magnitude 128
        '{1'b1, 3'b000, 1'b0, 1'b0, 8'h80, 8'h00, 8'h7F, 8'h80, 3'b001, 1'b1},
        // R3: threshold 0 always reached
        '{1'b0, 3'b000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 3'b111, 1'b1},
        // R2 R6: X off, others below 50
        '{1'b0, 3'b001, 1'b0, 1'b0, 8'h64, 8'h01, 8'h01, 8'h32, 3'b000, 1'b0},
        // R2 R7: only Z enabled and it hits
        '{1'b1, 3'b011, 1'b0, 1'b1, 8'h64, 8'h64, 8'h01, 8'h32, 3'b100, 1'b1},
        // R8: all off, negative polarity
        '{1'b0, 3'b111, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h0A, 3'b000, 1'b0},
        // R5: signed thr -10, pos
        '{1'b0, 3'b000, 1'b1, 1'b0, 8'hFB, 8'hF6, 8'hF5, 8'hF6, 3'b011, 1'b1},
        // R5 R7: signed thr 20, neg
        '{1'b1, 3'b000, 1'b1, 1'b1, 8'h13, 8'h14, 8'h9C, 8'h14, 3'b101, 1'b0},
        // R5: signed thr 20, -30 does not reach
        '{1'b0, 3'b000, 1'b1, 1'b0, 8'hE2, 8'h14, 8'h00, 8'h14, 3'b010, 1'b1},
        // R3: same inputs in magnitude mode, -30 reaches
        '{1'b0, 3'b000, 1'b0, 1'b0, 8'hE2, 8'h14, 8'h00, 8'h14, 3'b011, 1'b1},
        // R5 R2 R7: Z off, signed thr 0, neg
        '{1'b1, 3'b100, 1'b1, 1'b1, 8'hFF, 8'hFB, 8'h05, 8'h00, 3'b011, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_vld = 1'b0;
    logic [7:0] axis_x = '0, axis_y = '0, axis_z = '0, thresh = '0;
    logic [2:0] axis_off = '0;
    logic       thr_signed = 1'b0, neg_pol = 1'b0, bw_sel = 1'b0;
    logic [2:0] axis_hit;
    logic       level_evt, bw_sel_q;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    lvl_detect_top #(.SAMPLE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .axis_x(axis_x), .axis_y(axis_y), .axis_z(axis_z), .thresh(thresh),
        .axis_off(axis_off), .thr_signed(thr_signed), .neg_pol(neg_pol),
        .bw_sel(bw_sel), .axis_hit(axis_hit), .level_evt(level_evt),
        .bw_sel_q(bw_sel_q)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        axis_x = v.x; axis_y = v.y; axis_z = v.z; thresh = v.thr;
        axis_off = v.off; thr_signed = v.ts; neg_pol = v.np; bw_sel = v.bw;
        sample_vld = vld;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 hit in reset", axis_hit, 3'b000);
        check("R10 evt in reset", {2'b00, level_evt}, 3'b000);
        check("R10 bw in reset", {2'b00, bw_sel_q}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            check($sformatf("R2 R3 R4 R5 hit vec%0d", i), axis_hit, VECS[i].eh);
            check($sformatf("R6 R7 R8 evt vec%0d", i), {2'b00, level_evt}, {2'b00, VECS[i].ee});
            check($sformatf("R9 bw vec%0d", i), {2'b00, bw_sel_q}, {2'b00, VECS[i].bw});
        end
        // R1: last vector left hit=011 evt=1 bw=1; idle strobe with new inputs
        drive(VECS[7], 1'b0);
        bw_sel = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 hold hit", axis_hit, 3'b011);
        check("R1 hold evt", {2'b00, level_evt}, 3'b001);
        check("R1 hold bw", {2'b00, bw_sel_q}, 3'b001);
        // R1: strobe applies them one edge later
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        check("R1 R8 update hit", axis_hit, 3'b000);
        check("R1 R8 update evt", {2'b00, level_evt}, 3'b000);
        // R10: reset clears state mid-run
        drive(VECS[4], 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 hit after reset", axis_hit, 3'b000);
        check("R10 evt after reset", {2'b00, level_evt}, 3'b000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule